// File: doc/BRIEF.md
# Command-Tagged SPI Transmit Queue

This block sits between a register interface and a serial frame engine of an SPI controller. Software writes 32-bit push words; the upper half of each word is a per-frame command and the lower half is the data to shift out. The block keeps up to four such words in order. It hands them one at a time to the frame engine, which reports the end of each frame with a single-cycle done pulse carrying the received word. Serial clock generation and the delays around it belong to the frame engine and are not part of this block.

Because every queued data word has its own command, chip-select behaviour is decided frame by frame. The select lines can stay low across a run of frames, or they can return high between frames. Each command also names its timing attribute set, can mark the end of a queue, and can restart the frame counter. Received words collect in a four-entry receive queue read through a pop port. A 16-bit frame counter and a set of write-one-to-clear status flags report progress.

Top module: `spq_push_queue`

## Requirements
- R1: A push word is split with the command in bits [31:16] and the data in bits [15:0]. Frames are presented in push order: `frm_data` is the data half and `frm_attr` is command bits [14:12].
- R2: When no frame is in progress and the queue holds an entry, that entry becomes the current frame at the next clock edge. A word pushed into an empty, idle block therefore shows on `frm_busy` two edges after the push cycle.
- R3: A push made while four entries are queued is dropped and sets status bit 27. Entries already queued are unaffected.
- R4: After reset all `cs_n` lines are high. While a frame is in progress, `cs_n` is low exactly on the lines set in command bits [5:0] (one-hot) of that frame.
- R5: A done pulse for a frame with command bit 15 set, arriving while another entry is queued, loads the next frame at the same edge and leaves no cycle with `cs_n` all high. In every other case, `cs_n` returns to all ones at the edge that ends the frame.
- R6: The frame counter, read in bits [31:16] of `xfer_cnt` with the low half zero, increments at each completed frame. When the completed frame has command bit 10 set, the counter is cleared first and then counted, so it reads 1.
- R7: Each completed frame sets status bit 31. A completed frame with command bit 11 set also sets status bit 28. A status write clears every flag whose bit is 1 in `stat_wdata`. When a flag is set and cleared in the same cycle, the set wins.
- R8: The received word of each completed frame is appended to a four-entry receive queue. `pop_word` shows the oldest entry zero-extended, or zero when the queue is empty. `pop_re` discards the oldest entry, and has no effect on an empty queue. A frame that completes while the receive queue is full has its word dropped and sets status bit 19.
- R9: `flush_tx` empties the transmit queue but lets the frame in progress finish. `flush_rx` empties the receive queue. A push or pop made in a flush cycle on the same queue is discarded.
- R10: A done pulse while no frame is in progress has no effect on the counter, the flags or the receive queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_we | input | 1 | Push write strobe |
| push_word | input | 32 | Command [31:16] and transmit data [15:0] |
| flush_tx | input | 1 | Empty the transmit queue |
| flush_rx | input | 1 | Empty the receive queue |
| pop_re | input | 1 | Discard the oldest received word |
| pop_word | output | 32 | Oldest received word, zero-extended; zero when empty |
| xfer_cnt | output | 32 | Frame counter in bits [31:16] |
| stat_we | input | 1 | Status write strobe (write one to clear) |
| stat_wdata | input | 32 | Mask of flags to clear |
| stat | output | 32 | Flags: 31 frame done, 28 end of queue, 27 push dropped, 19 receive dropped |
| frm_busy | output | 1 | A frame is being handed to the engine |
| frm_data | output | 16 | Data of the current frame |
| frm_attr | output | 3 | Timing attribute set of the current frame |
| frm_done | input | 1 | Engine pulse: current frame complete |
| frm_rxd | input | 16 | Word received in the completing frame |
| cs_n | output | NCS | Active-low chip selects |

## Verification
Each result has a fixed due cycle. A push reaches the queue at the next edge, so in an idle block the frame and its chip select appear one edge later. A done pulse updates the chip selects, the counter, the flags and the receive queue at the edge where it is sampled. Pops and status clears take effect at the edge that samples them. The bench drives inputs and samples outputs at falling edges, and it advances its behavioural queue model at each rising edge. In every cycle after reset it compares each output with that model, so any result that arrives one edge early or late is reported. Scripted checks add fixed expected values for the corner cases.

// File: rtl/spq_pkg.sv
package spq_pkg;
  localparam int CNT_W  = 16;
  localparam int ST_TCF = 31;
  localparam int ST_EOQ = 28;
  localparam int ST_TXO = 27;
  localparam int ST_RXO = 19;

  typedef struct packed {
    logic       cont;   // hold select after this frame
    logic [2:0] attr;   // timing attribute set
    logic       eoq;    // end-of-queue marker
    logic       ctcnt;  // restart counter before counting
    logic [3:0] rsv;
    logic [5:0] pcs;    // one-hot chip select
  } spq_cmd_t;

  typedef struct packed {
    spq_cmd_t    cmd;
    logic [15:0] data;
  } spq_entry_t;
endpackage

// File: rtl/spq_fifo.sv
module spq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] lvl_q, lvl_d;
  logic          wr_ok, rd_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty = (lvl_q == '0);
  assign full  = (lvl_q == CW'(DEPTH));
  assign wr_ok = wr_en & ~full & ~flush;
  assign rd_ok = rd_en & ~empty & ~flush;
  assign head  = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    lvl_d = lvl_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      lvl_d = '0;
    end else begin
      if (wr_ok) wp_d = bump(wp_q);
      if (rd_ok) rp_d = bump(rp_q);
      lvl_d = lvl_q + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_ok && (wp_q == AW'(i))) mem[i] <= wr_data;
    end
  end

  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= CW'(DEPTH));
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !flush) |=> (full && $stable(head)));
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/spq_seq.sv
module spq_seq
  import spq_pkg::*;
#(
  parameter int NCS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_avail,
  input  spq_entry_t       q_head,
  output logic             q_pop,
  input  logic             frm_done,
  output logic             frm_busy,
  output logic [15:0]      frm_data,
  output logic [2:0]       frm_attr,
  output logic [NCS-1:0]   cs_n,
  output logic             fin,
  output logic             fin_eoq,
  output logic [CNT_W-1:0] count
);
  spq_entry_t       cur_q;
  logic             busy_q, busy_d;
  logic [NCS-1:0]   cs_q, cs_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             load;

  assign fin     = frm_done & busy_q;
  assign load    = q_avail & (~busy_q | (fin & cur_q.cmd.cont));
  assign q_pop   = load;
  assign fin_eoq = cur_q.cmd.eoq;

  always_comb begin
    busy_d = busy_q;
    cs_d   = cs_q;
    cnt_d  = cnt_q;
    if (load) begin
      busy_d = 1'b1;
      cs_d   = ~q_head.cmd.pcs[NCS-1:0];
    end else if (fin) begin
      busy_d = 1'b0;
      cs_d   = '1;
    end
    if (fin) cnt_d = cur_q.cmd.ctcnt ? CNT_W'(1) : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cs_q   <= '1;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cs_q   <= cs_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) cur_q <= q_head;
  end

  assign frm_busy = busy_q;
  assign frm_data = cur_q.data;
  assign frm_attr = cur_q.cmd.attr;
  assign cs_n     = cs_q;
  assign count    = cnt_q;

  p_cs_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !(cur_q.cmd.cont && q_avail)) |=> (cs_n == '1));
  p_cs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && cur_q.cmd.cont && q_avail) |=> (frm_busy && cs_n == ~$past(q_head.cmd.pcs[NCS-1:0])));
  p_idle_cs_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_busy |-> (cs_n == '1));
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !cur_q.cmd.ctcnt) |=> (count == $past(count) + CNT_W'(1)));
  p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(count));
  p_start_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_busy && q_avail) |=> frm_busy);
endmodule

// File: rtl/spq_status.sv
module spq_status
  import spq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  set_v,     // {rxo, txo, eoq, tcf}
  input  logic        clr_we,
  input  logic [31:0] clr_mask,
  output logic [31:0] stat
);
  logic [3:0] flag_q, flag_d, clr_v;

  always_comb begin
    clr_v[0] = clr_we & clr_mask[ST_TCF];
    clr_v[1] = clr_we & clr_mask[ST_EOQ];
    clr_v[2] = clr_we & clr_mask[ST_TXO];
    clr_v[3] = clr_we & clr_mask[ST_RXO];
    flag_d   = set_v | (flag_q & ~clr_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  always_comb begin
    stat         = '0;
    stat[ST_TCF] = flag_q[0];
    stat[ST_EOQ] = flag_q[1];
    stat[ST_TXO] = flag_q[2];
    stat[ST_RXO] = flag_q[3];
  end

  p_done_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_v[0] |=> stat[ST_TCF]);
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_mask[ST_TCF] && !set_v[0]) |=> !stat[ST_TCF]);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[ST_EOQ] && !(clr_we && clr_mask[ST_EOQ])) |=> stat[ST_EOQ]);
endmodule

// File: rtl/spq_push_queue.sv
module spq_push_queue
  import spq_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int RX_DEPTH = 4,
  parameter int NCS      = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_we,
  input  logic [31:0]    push_word,
  input  logic           flush_tx,
  input  logic           flush_rx,
  input  logic           pop_re,
  output logic [31:0]    pop_word,
  output logic [31:0]    xfer_cnt,
  input  logic           stat_we,
  input  logic [31:0]    stat_wdata,
  output logic [31:0]    stat,
  output logic           frm_busy,
  output logic [15:0]    frm_data,
  output logic [2:0]     frm_attr,
  input  logic           frm_done,
  input  logic [15:0]    frm_rxd,
  output logic [NCS-1:0] cs_n
);
  spq_entry_t       tx_head;
  logic             tx_empty, tx_full, tx_pop;
  logic [15:0]      rx_head;
  logic             rx_empty, rx_full;
  logic             fin, fin_eoq;
  logic [CNT_W-1:0] count;
  logic [3:0]       set_v;

  spq_fifo #(.W(32), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush_tx),
    .wr_en(push_we), .wr_data(push_word), .rd_en(tx_pop),
    .head(tx_head), .empty(tx_empty), .full(tx_full)
  );

  spq_seq #(.NCS(NCS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .q_avail(~tx_empty & ~flush_tx), .q_head(tx_head), .q_pop(tx_pop),
    .frm_done(frm_done), .frm_busy(frm_busy), .frm_data(frm_data),
    .frm_attr(frm_attr), .cs_n(cs_n), .fin(fin), .fin_eoq(fin_eoq),
    .count(count)
  );

  spq_fifo #(.W(16), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush_rx),
    .wr_en(fin), .wr_data(frm_rxd), .rd_en(pop_re),
    .head(rx_head), .empty(rx_empty), .full(rx_full)
  );

  assign set_v = {fin & rx_full, push_we & tx_full, fin & fin_eoq, fin};

  spq_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_v(set_v),
    .clr_we(stat_we), .clr_mask(stat_wdata), .stat(stat)
  );

  assign pop_word = rx_empty ? 32'h0 : {16'h0, rx_head};
  assign xfer_cnt = {count, 16'h0};

  p_push_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_we && tx_full) |=> stat[ST_TXO]);
  p_rx_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && frm_busy && rx_full) |=> stat[ST_RXO]);
  p_empty_pop_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> (pop_word == 32'h0));
endmodule

// File: tb/sim_spq_push_queue.sv
`timescale 1ns/1ps
module sim_spq_push_queue;
  localparam int NCS = 6;
  localparam int QD  = 4;

  logic clk, rst_n;
  logic push_we, flush_tx, flush_rx, pop_re, stat_we, frm_done;
  logic [31:0] push_word, stat_wdata, pop_word, xfer_cnt, stat;
  logic [15:0] frm_rxd, frm_data;
  logic [2:0] frm_attr;
  logic frm_busy;
  logic [NCS-1:0] cs_n;

  int total = 0, fails = 0;
  bit finished = 0;

  spq_push_queue #(.DEPTH(QD), .RX_DEPTH(QD), .NCS(NCS)) u0 (
    .clk(clk), .rst_n(rst_n), .push_we(push_we), .push_word(push_word),
    .flush_tx(flush_tx), .flush_rx(flush_rx), .pop_re(pop_re),
    .pop_word(pop_word), .xfer_cnt(xfer_cnt), .stat_we(stat_we),
    .stat_wdata(stat_wdata), .stat(stat), .frm_busy(frm_busy),
    .frm_data(frm_data), .frm_attr(frm_attr), .frm_done(frm_done),
    .frm_rxd(frm_rxd), .cs_n(cs_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [31:0] mtx[$];
  logic [15:0] mrx[$];
  logic [31:0] m_cur, m_st, m_set;
  logic [15:0] m_cnt;
  logic [NCS-1:0] m_cs;
  bit m_busy, m_fin, m_avail, m_load;
  int tsz, rsz;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mtx.delete(); mrx.delete();
      m_busy = 0; m_cur = '0; m_cs = '1; m_cnt = '0; m_st = '0;
    end else begin
      tsz = mtx.size();
      rsz = mrx.size();
      m_fin = frm_done && m_busy;
      m_avail = (tsz > 0) && !flush_tx;
      m_set = '0;
      if (m_fin) begin
        m_cnt = m_cur[26] ? 16'd1 : m_cnt + 16'd1;
        m_set[31] = 1'b1;
        if (m_cur[27]) m_set[28] = 1'b1;
        if (rsz == QD) m_set[19] = 1'b1;
      end
      if (push_we && tsz == QD) m_set[27] = 1'b1;
      m_load = m_avail && (!m_busy || (m_fin && m_cur[31]));
      if (m_load) begin
        m_cur = mtx.pop_front();
        m_busy = 1;
        m_cs = ~m_cur[16 +: NCS];
      end else if (m_fin) begin
        m_busy = 0;
        m_cs = '1;
      end
      if (flush_tx) mtx.delete();
      else if (push_we && tsz < QD) mtx.push_back(push_word);
      if (flush_rx) mrx.delete();
      else begin
        if (pop_re && rsz > 0) void'(mrx.pop_front());
        if (m_fin && rsz < QD) mrx.push_back(frm_rxd);
      end
      m_st = (m_st & ~(stat_we ? stat_wdata : 32'h0)) | m_set;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4/R5 cs_n", 32'(cs_n), 32'(m_cs));
      chk("R2 frm_busy", 32'(frm_busy), 32'(m_busy));
      if (m_busy) begin
        chk("R1 frm_data", 32'(frm_data), 32'(m_cur[15:0]));
        chk("R1 frm_attr", 32'(frm_attr), 32'(m_cur[30:28]));
      end
      chk("R7 stat", stat, m_st);
      chk("R6 xfer_cnt", xfer_cnt, {m_cnt, 16'h0});
      chk("R8 pop_word", pop_word, (mrx.size() > 0) ? {16'h0, mrx[0]} : 32'h0);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] w);
    push_we = 1; push_word = w; tick(); push_we = 0;
  endtask

  task automatic fdone(input logic [15:0] v);
    while (!frm_busy) tick();
    frm_done = 1; frm_rxd = v; tick(); frm_done = 0;
  endtask

  task automatic pop();
    pop_re = 1; tick(); pop_re = 0;
  endtask

  task automatic wclr(input logic [31:0] m);
    stat_we = 1; stat_wdata = m; tick(); stat_we = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  logic [31:0] saved;
  initial begin
    rst_n = 0; push_we = 0; push_word = '0; flush_tx = 0; flush_rx = 0;
    pop_re = 0; stat_we = 0; stat_wdata = '0; frm_done = 0; frm_rxd = '0;
    repeat (3) tick();
    rst_n = 1;
    chk("R4 reset cs_n", 32'(cs_n), 32'h3F);
    chk("R7 reset stat", stat, 32'h0);
    chk("R6 reset count", xfer_cnt, 32'h0);
    chk("R8 reset pop", pop_word, 32'h0);

    // continue-held pair: cont, attr 2, pcs bit1 then plain pcs bit2
    push(32'hA002_A5A5);
    chk("R2 not yet busy", 32'(frm_busy), 32'h0);
    tick();
    chk("R2 busy", 32'(frm_busy), 32'h1);
    chk("R1 data", 32'(frm_data), 32'hA5A5);
    chk("R1 attr", 32'(frm_attr), 32'h2);
    chk("R4 select", 32'(cs_n), 32'h3D);
    push(32'h0004_1234);
    fdone(16'h1111);
    chk("R5 held into next", 32'(cs_n), 32'h3B);
    chk("R5 next data", 32'(frm_data), 32'h1234);
    chk("R6 one frame", xfer_cnt, 32'h0001_0000);
    fdone(16'h2222);
    chk("R5 released", 32'(cs_n), 32'h3F);
    chk("R6 two frames", xfer_cnt, 32'h0002_0000);
    chk("R7 done flag", stat, 32'h8000_0000);
    chk("R8 oldest", pop_word, 32'h1111);
    pop();
    chk("R8 second", pop_word, 32'h2222);
    pop();
    chk("R8 empty zero", pop_word, 32'h0);
    pop();
    chk("R8 empty pop", pop_word, 32'h0);
    wclr(32'h8000_0000);
    chk("R7 w1c", stat, 32'h0);

    // counter restart + end of queue, clear collides with set
    push(32'h0C01_0055);
    tick();
    frm_done = 1; frm_rxd = 16'h0077; stat_we = 1; stat_wdata = 32'h8000_0000;
    tick();
    frm_done = 0; stat_we = 0;
    chk("R6 restart", xfer_cnt, 32'h0001_0000);
    chk("R7 set wins + eoq", stat, 32'h9000_0000);
    wclr(32'h9000_0000);
    chk("R7 cleared", stat, 32'h0);

    // overflow of the transmit queue
    push_we = 1;
    for (int i = 0; i < 6; i++) begin
      push_word = 32'h0001_0300 + 32'(i);
      tick();
    end
    push_we = 0;
    chk("R3 push dropped flag", 32'(stat[27]), 32'h1);
    for (int i = 0; i < 5; i++) fdone(16'h0100 + 16'(i));
    repeat (2) tick();
    chk("R3 five frames only", 32'(frm_busy), 32'h0);
    chk("R8 rx dropped flag", 32'(stat[19]), 32'h1);
    chk("R8 rx order", pop_word, 32'h0077);

    // flushes
    flush_rx = 1; tick(); flush_rx = 0;
    chk("R9 rx flushed", pop_word, 32'h0);
    wclr(32'hFFFF_FFFF);
    push_we = 1;
    for (int i = 0; i < 3; i++) begin
      push_word = 32'h0001_0400 + 32'(i);
      tick();
    end
    push_we = 0;
    flush_tx = 1; tick(); flush_tx = 0;
    fdone(16'h0200);
    repeat (4) tick();
    chk("R9 tx flushed idle", 32'(frm_busy), 32'h0);
    chk("R9 cs idle", 32'(cs_n), 32'h3F);

    // done while idle
    wclr(32'hFFFF_FFFF);
    saved = xfer_cnt;
    frm_done = 1; frm_rxd = 16'hDEAD; tick(); frm_done = 0;
    tick();
    chk("R10 count", xfer_cnt, saved);
    chk("R10 stat", stat, 32'h0);
    chk("R10 rx head", pop_word, 32'h0200);
    pop();
    chk("R10 no extra rx", pop_word, 32'h0);

    repeat (3) tick();
    summary();
  end
endmodule